// File: doc/BRIEF.md
# Switch Port Statistics Snapshot Engine

This block keeps the traffic counters for every port of a small packet switch and gives software a stable copy of them to read. Each port feeds it single-cycle event strobes (broadcast frame received, broadcast frame sent, a received frame ending with or without a checksum error, a sent frame ending) together with the frame length on frame-end strobes. The block turns these into six live counters per port. Three count events and are 32 bits wide. Three count bytes and are 64 bits wide.

Software never reads the live counters. It writes a capture command into the control word. The engine then raises a busy flag and walks through every counter of every port, one per clock. Each live value is copied into a shadow bank, which keeps that value until the next capture. Live counting goes on during the walk, so no event is lost. A flush command clears the live counters and the shadow bank together. While busy is set, a write to the control word is ignored.

The control word also holds a timer field and an auto-capture enable bit. These are only stored and read back. Reads use a one-cycle registered path: the word appears on the read data output after the clock edge that samples the read enable.

Top module: `stat_snap_engine`

## Requirements
- R1: After reset the control word reads 0 and every shadow counter reads 0.
- R2: With busy clear, a control write stores bits [15:0] (timer) and bit 16 (auto-capture enable). These read back exactly as written, and every bit outside [17:16], [15:0] and [26:24] reads 0.
- R3: Writing function code 3 in bits [26:24] starts a capture. Busy (bit 17) then reads 1 for exactly NUM_PORTS*6 cycles and then returns to 0.
- R4: After a capture, the shadow window of port p starts at byte address 0x20000 + p*0x100. The 32-bit counters sit at offsets 0x00 (broadcast received), 0x04 (frames received with checksum error) and 0x08 (broadcast sent). The 64-bit counters use a low/high word pair: good received bytes at 0x10/0x14, errored received bytes at 0x18/0x1C, and sent bytes at 0x20/0x24.
- R5: The 64-bit byte counters carry from the low word into the high word.
- R6: The shadow bank does not change between captures. Events that arrive after a capture has finished do not show in reads until the next capture.
- R7: Events that arrive while a capture walk is in progress are still counted by the live counters. A later capture includes them.
- R8: Function code 1 starts a flush. Busy reads 1 for exactly one cycle. Afterwards both the shadow bank and the live counters are zero.
- R9: A control write made while busy is set is ignored entirely: it starts no command and changes neither the timer nor the enable bit.
- R10: Function codes other than 1 and 3 start no operation: busy stays 0 and the shadow bank is unchanged.
- R11: Bits [26:24] of the control word read the code of the operation in progress while busy is set, and read 0 when idle.
- R12: Reads of port windows at or beyond NUM_PORTS, of unused offsets inside a window, and of unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte address, shared by reads and writes |
| wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data, registered, valid after the edge that samples rd_en |
| rx_bcast | input | NUM_PORTS | Per-port broadcast-received strobe |
| rx_end | input | NUM_PORTS | Per-port received-frame-end strobe |
| rx_err | input | NUM_PORTS | Per-port checksum-error qualifier for rx_end |
| rx_len | input | NUM_PORTS*LEN_W | Per-port received frame length, valid with rx_end |
| tx_bcast | input | NUM_PORTS | Per-port broadcast-sent strobe |
| tx_end | input | NUM_PORTS | Per-port sent-frame-end strobe |
| tx_len | input | NUM_PORTS*LEN_W | Per-port sent frame length, valid with tx_end |

## Verification
If the walk index goes wrong, the busy window has the wrong length. That shows on the control word within one capture, about 36 cycles. A wrong index can also leave a stale or misplaced counter, which shows at the first read after the capture. A shadow bank that takes a copy outside a capture makes values drift between two reads with no command in between. A live counter that is not cleared on flush, or that drops events during the walk, shows only one capture later, as a total that differs from the number of frames driven. A missing carry in a byte counter shows only once the low word has passed 2^32 bytes, so that case is driven all the way past the boundary.

// File: rtl/stat_snap_pkg.sv
package stat_snap_pkg;

    localparam int N_NARROW   = 3;
    localparam int N_WIDE     = 3;
    localparam int NUM_CNT    = N_NARROW + N_WIDE;
    localparam int CNT_IDX_W  = $clog2(NUM_CNT);
    localparam int NARROW_W   = 32;
    localparam int WIDE_W     = 64;

    localparam int CI_RX_BCAST = 0;
    localparam int CI_RX_FCS   = 1;
    localparam int CI_TX_BCAST = 2;
    localparam int CI_RX_GOOD  = 3;
    localparam int CI_RX_BAD   = 4;
    localparam int CI_TX_BYTES = 5;

    localparam logic [2:0] FN_NOP     = 3'd0;
    localparam logic [2:0] FN_FLUSH   = 3'd1;
    localparam logic [2:0] FN_CAPTURE = 3'd3;

    localparam int TIMER_W  = 16;
    localparam int HALF_BIT = 16;
    localparam int BUSY_BIT = 17;
    localparam int FN_LSB   = 24;

    localparam logic [17:0] SNAP_BASE     = 18'h20000;
    localparam int          PORT_SHIFT    = 8;
    localparam int          WIDE_OFF_BASE = 16;

    typedef logic [WIDE_W-1:0] cnt_t;
    typedef logic [NUM_CNT-1:0][WIDE_W-1:0] port_cnts_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CAPTURE,
        ST_FLUSH
    } op_state_e;

    function automatic logic cnt_is_wide(input int c);
        return c >= N_NARROW;
    endfunction

endpackage

// File: rtl/stat_live_bank.sv
module stat_live_bank
    import stat_snap_pkg::*;
#(
    parameter int NUM_PORTS = 6,
    parameter int LEN_W     = 16
) (
    input  logic                                        clk,
    input  logic                                        rst_n,
    input  logic                                        clr,
    input  logic [NUM_PORTS-1:0]                        rx_bcast,
    input  logic [NUM_PORTS-1:0]                        rx_end,
    input  logic [NUM_PORTS-1:0]                        rx_err,
    input  logic [NUM_PORTS*LEN_W-1:0]                  rx_len,
    input  logic [NUM_PORTS-1:0]                        tx_bcast,
    input  logic [NUM_PORTS-1:0]                        tx_end,
    input  logic [NUM_PORTS*LEN_W-1:0]                  tx_len,
    output logic [NUM_PORTS-1:0][NUM_CNT-1:0][WIDE_W-1:0] live
);

    typedef struct packed {
        port_cnts_t cnt;
    } live_st_t;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        live_st_t   st_d, st_q;
        port_cnts_t inc;
        cnt_t       rx_len_x, tx_len_x;

        assign rx_len_x = {{(WIDE_W-LEN_W){1'b0}}, rx_len[p*LEN_W +: LEN_W]};
        assign tx_len_x = {{(WIDE_W-LEN_W){1'b0}}, tx_len[p*LEN_W +: LEN_W]};

        always_comb begin
            inc              = '0;
            inc[CI_RX_BCAST] = {{(WIDE_W-1){1'b0}}, rx_bcast[p]};
            inc[CI_RX_FCS]   = {{(WIDE_W-1){1'b0}}, rx_end[p] & rx_err[p]};
            inc[CI_TX_BCAST] = {{(WIDE_W-1){1'b0}}, tx_bcast[p]};
            inc[CI_RX_GOOD]  = (rx_end[p] && !rx_err[p]) ? rx_len_x : '0;
            inc[CI_RX_BAD]   = (rx_end[p] &&  rx_err[p]) ? rx_len_x : '0;
            inc[CI_TX_BYTES] = tx_end[p] ? tx_len_x : '0;

            st_d = st_q;
            for (int c = 0; c < NUM_CNT; c++) begin
                cnt_t sum;
                sum = st_q.cnt[c] + inc[c];
                if (!cnt_is_wide(c)) begin
                    sum[WIDE_W-1:NARROW_W] = '0;
                end
                st_d.cnt[c] = clr ? '0 : sum;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                st_q <= '0;
            end else begin
                st_q <= st_d;
            end
        end

        assign live[p] = st_q.cnt;
    end

endmodule

// File: rtl/stat_cmd_ctrl.sv
module stat_cmd_ctrl
    import stat_snap_pkg::*;
#(
    parameter int NUM_PORTS = 6
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          ctl_wr,
    input  logic [2:0]                    wr_fn,
    input  logic [TIMER_W-1:0]            wr_timer,
    input  logic                          wr_half,
    output logic                          busy,
    output logic [31:0]                   ctl_word,
    output logic                          cap_wr,
    output logic [$clog2(NUM_PORTS)-1:0]  cap_port,
    output logic [CNT_IDX_W-1:0]          cap_cnt,
    output logic                          clr
);

    localparam int PORT_W = $clog2(NUM_PORTS);
    localparam logic [PORT_W-1:0]    LAST_PORT = PORT_W'(NUM_PORTS - 1);
    localparam logic [CNT_IDX_W-1:0] LAST_CNT  = CNT_IDX_W'(NUM_CNT - 1);

    typedef struct packed {
        op_state_e             st;
        logic [TIMER_W-1:0]    timer;
        logic                  half;
        logic [PORT_W-1:0]     port;
        logic [CNT_IDX_W-1:0]  cnt;
    } ctl_st_t;

    ctl_st_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        cap_wr = 1'b0;
        clr    = 1'b0;
        unique case (st_q.st)
            ST_IDLE: begin
                if (ctl_wr) begin
                    st_d.timer = wr_timer;
                    st_d.half  = wr_half;
                    if (wr_fn == FN_CAPTURE) begin
                        st_d.st   = ST_CAPTURE;
                        st_d.port = '0;
                        st_d.cnt  = '0;
                    end else if (wr_fn == FN_FLUSH) begin
                        st_d.st = ST_FLUSH;
                    end
                end
            end
            ST_CAPTURE: begin
                cap_wr = 1'b1;
                if (st_q.cnt == LAST_CNT) begin
                    st_d.cnt = '0;
                    if (st_q.port == LAST_PORT) begin
                        st_d.st = ST_IDLE;
                    end else begin
                        st_d.port = st_q.port + PORT_W'(1);
                    end
                end else begin
                    st_d.cnt = st_q.cnt + CNT_IDX_W'(1);
                end
            end
            ST_FLUSH: begin
                clr     = 1'b1;
                st_d.st = ST_IDLE;
            end
            default: st_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{st: ST_IDLE, default: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign busy     = (st_q.st != ST_IDLE);
    assign cap_port = st_q.port;
    assign cap_cnt  = st_q.cnt;

    always_comb begin
        ctl_word                    = '0;
        ctl_word[TIMER_W-1:0]       = st_q.timer;
        ctl_word[HALF_BIT]          = st_q.half;
        ctl_word[BUSY_BIT]          = busy;
        ctl_word[FN_LSB +: 3]       = (st_q.st == ST_CAPTURE) ? FN_CAPTURE :
                                      (st_q.st == ST_FLUSH)   ? FN_FLUSH   : FN_NOP;
    end

endmodule

// File: rtl/stat_shadow_bank.sv
module stat_shadow_bank
    import stat_snap_pkg::*;
#(
    parameter int NUM_PORTS = 6
) (
    input  logic                                          clk,
    input  logic                                          rst_n,
    input  logic                                          clr,
    input  logic                                          cap_wr,
    input  logic [$clog2(NUM_PORTS)-1:0]                  cap_port,
    input  logic [CNT_IDX_W-1:0]                          cap_cnt,
    input  logic [NUM_PORTS-1:0][NUM_CNT-1:0][WIDE_W-1:0] live,
    input  logic [$clog2(NUM_PORTS)-1:0]                  rd_port,
    input  logic [PORT_SHIFT-1:0]                         rd_off,
    output logic [31:0]                                   rd_word
);

    typedef struct packed {
        logic [NUM_PORTS-1:0][NUM_CNT-1:0][WIDE_W-1:0] shd;
    } shd_st_t;

    shd_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.shd = '0;
        end else if (cap_wr) begin
            st_d.shd[cap_port][cap_cnt] = live[cap_port][cap_cnt];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rd_word = '0;
        if (32'(rd_port) < NUM_PORTS) begin
            for (int c = 0; c < NUM_CNT; c++) begin
                if (!cnt_is_wide(c)) begin
                    if (rd_off == PORT_SHIFT'(4 * c)) begin
                        rd_word = st_q.shd[rd_port][c][31:0];
                    end
                end else begin
                    if (rd_off == PORT_SHIFT'(WIDE_OFF_BASE + 8 * (c - N_NARROW))) begin
                        rd_word = st_q.shd[rd_port][c][31:0];
                    end
                    if (rd_off == PORT_SHIFT'(WIDE_OFF_BASE + 8 * (c - N_NARROW) + 4)) begin
                        rd_word = st_q.shd[rd_port][c][63:32];
                    end
                end
            end
        end
    end

endmodule

// File: rtl/stat_snap_engine.sv
module stat_snap_engine
    import stat_snap_pkg::*;
#(
    parameter int NUM_PORTS = 6,
    parameter int LEN_W     = 16,
    parameter int ADDR_W    = 18
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic                       rd_en,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [31:0]                wdata,
    output logic [31:0]                rd_data,
    input  logic [NUM_PORTS-1:0]       rx_bcast,
    input  logic [NUM_PORTS-1:0]       rx_end,
    input  logic [NUM_PORTS-1:0]       rx_err,
    input  logic [NUM_PORTS*LEN_W-1:0] rx_len,
    input  logic [NUM_PORTS-1:0]       tx_bcast,
    input  logic [NUM_PORTS-1:0]       tx_end,
    input  logic [NUM_PORTS*LEN_W-1:0] tx_len
);

    localparam int PORT_W = $clog2(NUM_PORTS);
    localparam int TAG_LSB = PORT_SHIFT + PORT_W;
    localparam logic [ADDR_W-1:0] SNAP_BASE_A = ADDR_W'(SNAP_BASE);

    typedef struct packed {
        logic [31:0] data;
    } rd_st_t;

    logic                                          ctl_hit, snap_hit;
    logic                                          busy_w, cap_wr_w, clr_w;
    logic [31:0]                                   ctl_word_w, shd_word_w;
    logic [PORT_W-1:0]                             cap_port_w;
    logic [CNT_IDX_W-1:0]                          cap_cnt_w;
    logic [NUM_PORTS-1:0][NUM_CNT-1:0][WIDE_W-1:0] live_w;
    logic                                          unused_wdata;
    rd_st_t                                        rd_d, rd_q;

    assign ctl_hit  = (addr == '0);
    assign snap_hit = (addr[ADDR_W-1:TAG_LSB] == SNAP_BASE_A[ADDR_W-1:TAG_LSB]);
    assign unused_wdata = ^{wdata[31:27], wdata[23:17]};

    stat_cmd_ctrl #(.NUM_PORTS(NUM_PORTS)) ctrl_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctl_wr   (wr_en & ctl_hit),
        .wr_fn    (wdata[FN_LSB +: 3]),
        .wr_timer (wdata[TIMER_W-1:0]),
        .wr_half  (wdata[HALF_BIT]),
        .busy     (busy_w),
        .ctl_word (ctl_word_w),
        .cap_wr   (cap_wr_w),
        .cap_port (cap_port_w),
        .cap_cnt  (cap_cnt_w),
        .clr      (clr_w)
    );

    stat_live_bank #(.NUM_PORTS(NUM_PORTS), .LEN_W(LEN_W)) live_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr_w),
        .rx_bcast (rx_bcast),
        .rx_end   (rx_end),
        .rx_err   (rx_err),
        .rx_len   (rx_len),
        .tx_bcast (tx_bcast),
        .tx_end   (tx_end),
        .tx_len   (tx_len),
        .live     (live_w)
    );

    stat_shadow_bank #(.NUM_PORTS(NUM_PORTS)) shadow_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr_w),
        .cap_wr   (cap_wr_w),
        .cap_port (cap_port_w),
        .cap_cnt  (cap_cnt_w),
        .live     (live_w),
        .rd_port  (addr[PORT_SHIFT +: PORT_W]),
        .rd_off   (addr[PORT_SHIFT-1:0]),
        .rd_word  (shd_word_w)
    );

    always_comb begin
        rd_d = rd_q;
        if (rd_en) begin
            if (ctl_hit) begin
                rd_d.data = ctl_word_w;
            end else if (snap_hit) begin
                rd_d.data = shd_word_w;
            end else begin
                rd_d.data = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign rd_data = rd_q.data;

endmodule

// File: rtl/stat_snap_checker.sv
module stat_snap_checker
    import stat_snap_pkg::*;
#(
    parameter int NUM_PORTS = 6,
    parameter int ADDR_W    = 18
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [31:0]       wdata,
    input logic              busy,
    input logic [31:0]       ctl_word,
    input logic              cap_wr,
    input logic              clr
);

    localparam int NUM_ENT = NUM_PORTS * NUM_CNT;
    localparam int RUN_W   = $clog2(NUM_ENT + 2);

    logic [RUN_W-1:0] busy_run_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_run_q <= '0;
        end else if (busy) begin
            busy_run_q <= busy_run_q + RUN_W'(1);
        end else begin
            busy_run_q <= '0;
        end
    end

    assert_busy_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        busy_run_q <= RUN_W'(NUM_ENT));

    assert_copy_in_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cap_wr |-> ctl_word[BUSY_BIT]);

    assert_flush_one_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !busy);

    assert_busy_write_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_en && addr == '0) |=> $stable(ctl_word[HALF_BIT:0]));

    assert_idle_write_stored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && wr_en && addr == '0) |=> ctl_word[HALF_BIT:0] == $past(wdata[HALF_BIT:0]));

    assert_idle_fn_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> ctl_word[FN_LSB +: 3] == FN_NOP);

endmodule

bind stat_snap_engine stat_snap_checker #(
    .NUM_PORTS (NUM_PORTS),
    .ADDR_W    (ADDR_W)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .addr     (addr),
    .wdata    (wdata),
    .busy     (busy_w),
    .ctl_word (ctl_word_w),
    .cap_wr   (cap_wr_w),
    .clr      (clr_w)
);

// File: tb/stat_snap_engine_tb_top.sv
module stat_snap_engine_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NP = 6;
    localparam int LW = 16;
    localparam int AW = 18;
    localparam int NVEC = 5;

    // vector: {port[3], frames[8], err[1], rx_len[16], tx_len[16]}
    localparam logic [43:0] VEC [NVEC] = '{
        {3'd0, 8'd5,  1'b0, 16'd64,    16'd100},
        {3'd1, 8'd3,  1'b1, 16'd1518,  16'd60},
        {3'd5, 8'd20, 1'b0, 16'd1000,  16'd1500},
        {3'd2, 8'd1,  1'b1, 16'd65535, 16'd65535},
        {3'd4, 8'd0,  1'b0, 16'd10,    16'd10}
    };

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           wr_en = 1'b0, rd_en = 1'b0;
    logic [AW-1:0]  addr = '0;
    logic [31:0]    wdata = '0;
    logic [31:0]    rd_data;
    logic [NP-1:0]  rx_bcast = '0, rx_end = '0, rx_err = '0;
    logic [NP-1:0]  tx_bcast = '0, tx_end = '0;
    logic [NP*LW-1:0] rx_len = '0, tx_len = '0;

    int total = 0;
    int bad = 0;

    stat_snap_engine #(.NUM_PORTS(NP), .LEN_W(LW), .ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rd_data(rd_data), .rx_bcast(rx_bcast), .rx_end(rx_end),
        .rx_err(rx_err), .rx_len(rx_len), .tx_bcast(tx_bcast), .tx_end(tx_end),
        .tx_len(tx_len)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%0h exp=%0h", req, got, exp);
        end
    endtask

    function automatic logic [31:0] ctlw(input logic [2:0] fn, input logic [15:0] tmr, input logic half);
        return {5'd0, fn, 7'd0, half, tmr};
    endfunction

    function automatic logic [AW-1:0] snap_addr(input int p, input int off);
        return AW'(32'h20000 + p * 256 + off);
    endfunction

    function automatic int cnt_off(input int c, input bit hi);
        return (c < 3) ? 4 * c : 16 + 8 * (c - 3) + (hi ? 4 : 0);
    endfunction

    task automatic reg_wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic reg_rd(input logic [AW-1:0] a, output logic [31:0] d);
        @(negedge clk); rd_en = 1'b1; addr = a;
        @(negedge clk); rd_en = 1'b0; d = rd_data;
    endtask

    task automatic rd_cnt(input int p, input int c, output logic [63:0] v);
        logic [31:0] lo, hi;
        reg_rd(snap_addr(p, cnt_off(c, 1'b0)), lo);
        hi = '0;
        if (c >= 3) reg_rd(snap_addr(p, cnt_off(c, 1'b1)), hi);
        v = {hi, lo};
    endtask

    task automatic frames(input int p, input int n, input bit err, input int rl, input int tl);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rx_bcast[p] = 1'b1; tx_bcast[p] = 1'b1;
            rx_end[p] = 1'b1; rx_err[p] = err; tx_end[p] = 1'b1;
            rx_len[p*LW +: LW] = LW'(rl); tx_len[p*LW +: LW] = LW'(tl);
        end
        if (n > 0) begin
            @(negedge clk);
            rx_bcast = '0; tx_bcast = '0; rx_end = '0; rx_err = '0; tx_end = '0;
        end
    endtask

    task automatic wait_idle();
        logic [31:0] w;
        for (int i = 0; i < 100; i++) begin
            reg_rd('0, w);
            if (!w[17]) break;
        end
    endtask

    task automatic run_cmd(input logic [2:0] fn, input logic [15:0] tmr);
        reg_wr('0, ctlw(fn, tmr, 1'b0));
        wait_idle();
    endtask

    // hold a read of the control word while commanding; count busy samples
    task automatic cmd_count(input logic [31:0] w, output int ones, output int fnbad);
        @(negedge clk); wr_en = 1'b1; rd_en = 1'b1; addr = '0; wdata = w;
        @(negedge clk); wr_en = 1'b0;
        ones = 0; fnbad = 0;
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            if (rd_data[17]) begin
                ones++;
                if (rd_data[26:24] !== w[26:24]) fnbad++;
            end
        end
        rd_en = 1'b0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] w;
        logic [63:0] v;
        logic [63:0] exp_c [6];
        int ones, fnbad;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        reg_rd('0, w);                          chk("R1 ctrl", 64'(w), 64'h0);
        rd_cnt(0, 0, v);                        chk("R1 snap p0", v, 64'h0);
        rd_cnt(3, 5, v);                        chk("R1 snap p3", v, 64'h0);

        // R2: field readback; R10: code 2 is no-op
        reg_wr('0, ctlw(3'd0, 16'hABCD, 1'b1));
        reg_rd('0, w);                          chk("R2 readback", 64'(w), 64'h0001ABCD);
        reg_wr('0, 32'hFAFC_1234);
        reg_rd('0, w);                          chk("R2 R10 masked", 64'(w), 64'h00001234);

        // R4 / R8: vector table
        for (int k = 0; k < NVEC; k++) begin
            int p, n, rl, tl;
            bit er;
            p = int'(VEC[k][43:41]); n = int'(VEC[k][40:33]); er = VEC[k][32];
            rl = int'(VEC[k][31:16]); tl = int'(VEC[k][15:0]);
            run_cmd(3'd1, 16'h0);
            frames(p, n, er, rl, tl);
            run_cmd(3'd3, 16'h0);
            exp_c[0] = 64'(n);
            exp_c[1] = er ? 64'(n) : 64'h0;
            exp_c[2] = 64'(n);
            exp_c[3] = er ? 64'h0 : 64'(n) * 64'(rl);
            exp_c[4] = er ? 64'(n) * 64'(rl) : 64'h0;
            exp_c[5] = 64'(n) * 64'(tl);
            for (int c = 0; c < 6; c++) begin
                rd_cnt(p, c, v);
                chk("R4 vector counter", v, exp_c[c]);
            end
            rd_cnt((p + 1) % NP, 0, v);         chk("R8 other port cleared", v, 64'h0);
        end

        // R6: frozen snapshot
        frames(1, 4, 1'b0, 100, 200);
        run_cmd(3'd3, 16'h0);
        frames(1, 3, 1'b0, 100, 200);
        rd_cnt(1, 3, v);                        chk("R6 frozen good bytes", v, 64'd400);
        rd_cnt(1, 0, v);                        chk("R6 frozen bcast", v, 64'd4);

        // R7: events during walk are kept
        reg_wr('0, ctlw(3'd3, 16'h0, 1'b0));
        frames(1, 10, 1'b0, 100, 200);
        wait_idle();
        run_cmd(3'd3, 16'h0);
        rd_cnt(1, 3, v);                        chk("R7 good bytes", v, 64'd1700);
        rd_cnt(1, 5, v);                        chk("R7 tx bytes", v, 64'd3400);

        // R9: write during busy ignored
        reg_wr('0, ctlw(3'd3, 16'h0042, 1'b0));
        reg_wr('0, ctlw(3'd1, 16'hBEEF, 1'b1));
        wait_idle();
        reg_rd('0, w);                          chk("R9 ctrl kept", 64'(w), 64'h00000042);
        rd_cnt(1, 0, v);                        chk("R9 no flush", v, 64'd17);

        // R3 / R11: capture busy length and function field
        cmd_count(ctlw(3'd3, 16'h0042, 1'b0), ones, fnbad);
        chk("R3 capture busy cycles", 64'(ones), 64'd36);
        chk("R11 fn while busy", 64'(fnbad), 64'd0);
        reg_rd('0, w);                          chk("R11 idle fn", 64'(w[26:24]), 64'd0);

        // R8: flush
        cmd_count(ctlw(3'd1, 16'h0007, 1'b0), ones, fnbad);
        chk("R8 flush busy cycles", 64'(ones), 64'd1);
        chk("R11 flush fn", 64'(fnbad), 64'd0);
        rd_cnt(1, 3, v);                        chk("R8 shadow cleared", v, 64'h0);
        frames(1, 2, 1'b0, 50, 0);
        run_cmd(3'd3, 16'h0);
        rd_cnt(1, 3, v);                        chk("R8 live cleared bytes", v, 64'd100);
        rd_cnt(1, 0, v);                        chk("R8 live cleared bcast", v, 64'd2);

        // R10: other codes do nothing
        frames(1, 5, 1'b0, 50, 0);
        cmd_count(ctlw(3'd7, 16'h1234, 1'b0), ones, fnbad);
        chk("R10 code7 no busy", 64'(ones), 64'd0);
        cmd_count(ctlw(3'd2, 16'h1234, 1'b0), ones, fnbad);
        chk("R10 code2 no busy", 64'(ones), 64'd0);
        rd_cnt(1, 0, v);                        chk("R10 snapshot unchanged", v, 64'd2);

        // R12: unmapped reads
        reg_rd(snap_addr(6, 0), w);             chk("R12 port6", 64'(w), 64'h0);
        reg_rd(snap_addr(1, 12), w);            chk("R12 gap offset", 64'(w), 64'h0);
        reg_rd(snap_addr(1, 40), w);            chk("R12 past end", 64'(w), 64'h0);
        reg_rd(AW'(4), w);                      chk("R12 unmapped", 64'(w), 64'h0);

        // R5: carry into high word of a byte counter
        run_cmd(3'd1, 16'h0);
        frames(3, 65538, 1'b0, 0, 65535);
        run_cmd(3'd3, 16'h0);
        rd_cnt(3, 5, v);                        chk("R5 tx byte carry", v, 64'd65538 * 64'd65535);
        rd_cnt(3, 0, v);                        chk("R5 narrow count", v, 64'd65538);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule